// File: doc/BRIEF.md
# Block Cipher Chaining Wrapper

This block sits between a simple register bus and an external 128-bit block cipher core. Software configures a chaining mode, a direction and a key size, and loads the key and initialization-vector registers while the block is disabled. Once enabled, software writes one 128-bit block as four 32-bit words. The wrapper applies ECB or CBC chaining around the core, raises a completion flag, and returns the result as four 32-bit words.

The cipher core is not part of this block. It is reached through a one-cycle start pulse, a 128-bit input, the selected direction, key and key size, and a done pulse that carries a 128-bit output. In CBC encryption the wrapper folds the chaining value into the core input. In CBC decryption it folds the chaining value into the core output and keeps the raw ciphertext as the next chaining value. The key stays loaded from one block to the next, so a message is a sequence of write-four, wait, read-four, clear.

Bus map (word addresses): 0 control, 1 status, 2 data-in, 3 data-out, 4..7 IV words, 8..15 key words. IV word at address 4+i holds bits [32i+31:32i] of the IV. Key word at address 8+i holds bits [32i+31:32i] of the key. Read data appears on `bus_rdata` one clock after the read strobe.

Top module: `blkchain_wrap`

## Requirements
- R1: Control bit 0 is the enable bit and may be written at any time. The direction, mode and key-size fields and the IV and key words only change on writes made while enable is 0. While enable is 1, writes to them are ignored.
- R2: Control bits [4:2] select the chaining mode: 000 is ECB and 001 is CBC. Every other code behaves as ECB.
- R3: A block takes four data-in writes, most significant word first. `core_start` pulses for one cycle, the cycle after the fourth accepted write, with the assembled block (ECB) on `core_din`. It does not pulse after fewer writes.
- R4: Status bit 0 (complete) is 0 after reset. It becomes 1 only on a `core_done` pulse for a block in flight.
- R5: Four data-out reads return the result, most significant word first. Any further data-out read, or a data-out read while the complete flag is 0, returns 0.
- R6: Writing control with bit 8 set clears status bits 0 and 1. A following block is processed with the same key, with no reload.
- R7: In CBC encryption (control bit 1 = 0), the core input is the plaintext XOR the chaining value. The core output is both the result and the next chaining value.
- R8: In CBC decryption (control bit 1 = 1), the ciphertext goes to the core unchanged. The result is the core output XOR the chaining value. That ciphertext becomes the next chaining value.
- R9: The first CBC block after enabling uses the IV registers as its chaining value.
- R10: A data-in write while a block is in flight, or while the complete flag is set, is ignored and sets status bit 1 (write error). It does not advance the word count.
- R11: Clearing enable aborts any block in flight, so a late `core_done` is ignored. It also clears status, resets both word counters and reloads the chaining value from the IV registers.
- R12: Control bit 5 selects a 256-bit key (1) or a 128-bit key (0). It drives `core_key256`, and the key registers drive `core_key`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid one cycle after `bus_rd` |
| core_start | output | 1 | One-cycle start pulse to the cipher core |
| core_decrypt | output | 1 | Direction to the core (1 = decrypt) |
| core_key256 | output | 1 | Key size to the core (1 = 256-bit) |
| core_key | output | KEY_W (256) | Key to the core |
| core_din | output | BLK_W (128) | Core input block |
| core_done | input | 1 | Core finished pulse |
| core_dout | input | BLK_W (128) | Core output block, valid with `core_done` |

## Verification
The bench sends data-in writes while the core is busy and again while the flag is set. A design that counted those words would misalign every later block. A design that did not flag them would leave the write-error bit low. The bench disables the block both mid-load and mid-computation, then checks that the next block chains from the IV. A design that kept a stale chaining value or a partial word count would return a wrong block, and one that honoured a late `core_done` would raise the flag unasked. CBC decryption is run on ciphertext the bench produced, so saving the core output instead of the raw ciphertext as the next chaining value corrupts every block after the first. The bench also reads past the fourth word and writes the key and direction while enabled, to catch results that leak or configuration that is not locked.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam logic [2:0] CHM_ECB = 3'b000;
  localparam logic [2:0] CHM_CBC = 3'b001;

  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_DIN  = 2;
  localparam int A_DOUT = 3;
  localparam int A_IV0  = 4;

  localparam int B_EN   = 0;
  localparam int B_DEC  = 1;
  localparam int B_MODE = 2;
  localparam int B_K256 = 5;
  localparam int B_CLR  = 8;

  typedef struct packed {
    logic       enable;
    logic       decrypt;
    logic [2:0] chmode;
    logic       key256;
  } cw_cfg_t;
endpackage

// File: rtl/cw_regs.sv
module cw_regs
  import cw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 128,
  parameter int KEY_W  = 256,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cw_cfg_t           cfg,
  output logic [BLK_W-1:0]  iv,
  output logic [KEY_W-1:0]  key,
  output logic              clr
);
  localparam int WORDS    = BLK_W / DATA_W;
  localparam int KWORDS   = KEY_W / DATA_W;
  localparam int KEY_BASE = A_IV0 + WORDS;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));
  assign clr     = ctrl_wr && wdata[B_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (ctrl_wr) begin
      cfg.enable <= wdata[B_EN];
      if (!cfg.enable) begin
        cfg.decrypt <= wdata[B_DEC];
        cfg.chmode  <= wdata[B_MODE +: 3];
        cfg.key256  <= wdata[B_K256];
      end
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_iv
    always_ff @(posedge clk) begin
      if (rst) iv[g*DATA_W +: DATA_W] <= '0;
      else if (wr_en && !cfg.enable && addr == ADDR_W'(A_IV0 + g))
        iv[g*DATA_W +: DATA_W] <= wdata;
    end
  end

  for (genvar g = 0; g < KWORDS; g++) begin : g_key
    always_ff @(posedge clk) begin
      if (rst) key[g*DATA_W +: DATA_W] <= '0;
      else if (wr_en && !cfg.enable && addr == ADDR_W'(KEY_BASE + g))
        key[g*DATA_W +: DATA_W] <= wdata;
    end
  end

  // R1
  key_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.enable && $past(cfg.enable)) |-> ($stable(key) && $stable(iv) && $stable(cfg.chmode)));
endmodule

// File: rtl/cw_din_pack.sv
module cw_din_pack #(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              accept,
  input  logic [DATA_W-1:0] wdata,
  output logic [BLK_W-1:0]  full_blk,
  output logic              last
);
  localparam int WORDS = BLK_W / DATA_W;
  localparam int CW    = $clog2(WORDS);
  localparam int HW    = BLK_W - DATA_W;

  logic [CW-1:0] cnt;
  logic [HW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt  <= '0;
      held <= '0;
    end else if (accept) begin
      cnt  <= (cnt == CW'(WORDS-1)) ? '0 : cnt + 1'b1;
      held <= {held[HW-DATA_W-1:0], wdata};
    end
  end

  assign full_blk = {held, wdata};
  assign last     = accept && (cnt == CW'(WORDS-1));
endmodule

// File: rtl/cw_chain.sv
module cw_chain #(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cbc,
  input  logic             decrypt,
  input  logic [BLK_W-1:0] iv,
  input  logic             launch,
  input  logic [BLK_W-1:0] blk,
  input  logic             clr,
  input  logic             core_done,
  input  logic [BLK_W-1:0] core_dout,
  output logic             core_start,
  output logic [BLK_W-1:0] core_din,
  output logic             busy,
  output logic             done_flag,
  output logic [BLK_W-1:0] result
);
  logic [BLK_W-1:0] chain_r;
  logic [BLK_W-1:0] ct_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_r    <= '0;
      ct_hold    <= '0;
      core_din   <= '0;
      core_start <= 1'b0;
      busy       <= 1'b0;
      done_flag  <= 1'b0;
      result     <= '0;
    end else if (!enable) begin
      chain_r    <= iv;
      core_start <= 1'b0;
      busy       <= 1'b0;
      done_flag  <= 1'b0;
    end else begin
      core_start <= 1'b0;
      if (clr) done_flag <= 1'b0;
      if (launch) begin
        core_din   <= (cbc && !decrypt) ? (blk ^ chain_r) : blk;
        ct_hold    <= blk;
        core_start <= 1'b1;
        busy       <= 1'b1;
      end else if (busy && core_done) begin
        busy      <= 1'b0;
        done_flag <= 1'b1;
        result    <= (cbc && decrypt) ? (core_dout ^ chain_r) : core_dout;
        if (cbc) chain_r <= decrypt ? ct_hold : core_dout;
      end
    end
  end

  // R4
  flag_from_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(core_done && busy));
  // R10
  no_launch_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    launch |-> (!busy && !done_flag));
  // R11
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!busy && !done_flag && !core_start));
endmodule

// File: rtl/blkchain_wrap.sv
module blkchain_wrap
  import cw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 128,
  parameter int KEY_W  = 256,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_start,
  output logic              core_decrypt,
  output logic              core_key256,
  output logic [KEY_W-1:0]  core_key,
  output logic [BLK_W-1:0]  core_din,
  input  logic              core_done,
  input  logic [BLK_W-1:0]  core_dout
);
  localparam int WORDS = BLK_W / DATA_W;
  localparam int OC_W  = $clog2(WORDS + 1);

  cw_cfg_t          cfg;
  logic [BLK_W-1:0] iv, full_blk, result;
  logic             clr, last, busy, done_flag, wrerr;
  logic             din_wr, din_accept, dout_rd, cbc;
  logic [OC_W-1:0]  out_cnt;
  logic [DATA_W-1:0] rd_word, ctrl_word;

  assign din_wr     = bus_wr && (bus_addr == ADDR_W'(A_DIN));
  assign din_accept = din_wr && cfg.enable && !busy && !done_flag;
  assign dout_rd    = bus_rd && (bus_addr == ADDR_W'(A_DOUT));
  assign cbc        = (cfg.chmode == CHM_CBC);

  cw_regs #(.DATA_W(DATA_W), .BLK_W(BLK_W), .KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cfg(cfg), .iv(iv), .key(core_key), .clr(clr)
  );

  cw_din_pack #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_pack (
    .clk(clk), .rst(rst), .flush(!cfg.enable), .accept(din_accept),
    .wdata(bus_wdata), .full_blk(full_blk), .last(last)
  );

  cw_chain #(.BLK_W(BLK_W)) u_chain (
    .clk(clk), .rst(rst), .enable(cfg.enable), .cbc(cbc), .decrypt(cfg.decrypt),
    .iv(iv), .launch(last), .blk(full_blk), .clr(clr),
    .core_done(core_done), .core_dout(core_dout),
    .core_start(core_start), .core_din(core_din), .busy(busy),
    .done_flag(done_flag), .result(result)
  );

  assign core_decrypt = cfg.decrypt;
  assign core_key256  = cfg.key256;

  always_ff @(posedge clk) begin
    if (rst || !cfg.enable) wrerr <= 1'b0;
    else if (din_wr && !din_accept) wrerr <= 1'b1;
    else if (clr) wrerr <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !cfg.enable) out_cnt <= '0;
    else if ((busy && core_done) || clr) out_cnt <= '0;
    else if (dout_rd && done_flag && out_cnt < OC_W'(WORDS)) out_cnt <= out_cnt + 1'b1;
  end

  always_comb begin
    rd_word = '0;
    if (done_flag)
      for (int i = 0; i < WORDS; i++)
        if (out_cnt == OC_W'(i)) rd_word = result[(WORDS-1-i)*DATA_W +: DATA_W];
    ctrl_word = '0;
    ctrl_word[B_EN]          = cfg.enable;
    ctrl_word[B_DEC]         = cfg.decrypt;
    ctrl_word[B_MODE +: 3]   = cfg.chmode;
    ctrl_word[B_K256]        = cfg.key256;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(A_CTRL): bus_rdata <= ctrl_word;
        ADDR_W'(A_STAT): bus_rdata <= DATA_W'({busy, wrerr, done_flag});
        ADDR_W'(A_DOUT): bus_rdata <= rd_word;
        default:         bus_rdata <= '0;
      endcase
    end
  end

  // R5
  drained_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_rd && out_cnt == OC_W'(WORDS)) |=> (bus_rdata == '0));
  // R3
  start_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    core_start |-> $past(din_accept));
endmodule

// File: tb/blkchain_wrap_tb.sv
module blkchain_wrap_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic core_start, core_decrypt, core_key256;
  logic [255:0] core_key;
  logic [127:0] core_din;
  logic core_done = 1'b0;
  logic [127:0] core_dout = '0;

  int checks = 0, failures = 0, starts = 0, m_cnt = 0;
  bit finished = 0;
  logic [127:0] last_in = '0;
  logic last_k256 = 1'b0;

  always #2 clk = ~clk;

  blkchain_wrap u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_start(core_start),
    .core_decrypt(core_decrypt), .core_key256(core_key256), .core_key(core_key),
    .core_din(core_din), .core_done(core_done), .core_dout(core_dout)
  );

  function automatic logic [127:0] core_f(input logic [127:0] d, input logic [255:0] k,
                                          input logic k256, input logic dec);
    logic [127:0] kx, t;
    kx = k[127:0] ^ (k256 ? k[255:128] : 128'd0);
    if (!dec) return {d[119:0], d[127:120]} ^ kx;
    t = d ^ kx;
    return {t[7:0], t[127:8]};
  endfunction

  // core model: fixed latency of 4 cycles from start to done
  logic [127:0] m_din;
  logic [255:0] m_key;
  logic m_dec, m_k256;
  always @(posedge clk) begin
    core_done <= 1'b0;
    if (rst) m_cnt <= 0;
    else if (core_start) begin
      m_din <= core_din; m_key <= core_key; m_dec <= core_decrypt; m_k256 <= core_key256;
      last_in <= core_din; last_k256 <= core_key256;
      starts <= starts + 1;
      m_cnt <= 3;
    end else if (m_cnt > 0) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1) begin
        core_done <= 1'b1;
        core_dout <= core_f(m_din, m_key, m_k256, m_dec);
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 4'(a);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic load_words(input logic [127:0] p, input int n);
    for (int i = 3; i > 3 - n; i--) wr(2, p[i*32 +: 32]);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 40; i++) begin
      rd(1, s);
      if (s[0]) break;
    end
    chk("R4 complete flag set", 128'(s[0]), 128'd1);
  endtask

  task automatic get_block(output logic [127:0] r);
    logic [31:0] w;
    for (int i = 3; i >= 0; i--) begin
      rd(3, w); r[i*32 +: 32] = w;
    end
  endtask

  logic [31:0] cur_ctrl = '0;
  task automatic run_block(input logic [127:0] p, output logic [127:0] r);
    load_words(p, 4);
    wait_done();
    get_block(r);
    wr(0, cur_ctrl | 32'h100);
  endtask

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [255:0] key;
    logic [127:0] iv, p, r, chain, e, p2;
    logic [127:0] pts[3], cts[3];
    logic [31:0] w;
    int s0;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    rd(1, w); chk("R4 reset status", 128'(w), 128'd0);
    rd(3, w); chk("R5 reset dout", 128'(w), 128'd0);
    chk("R3 no start at reset", 128'(starts), 128'd0);

    key = {r128(), r128()};
    iv  = r128();
    for (int i = 0; i < 8; i++) wr(8 + i, key[i*32 +: 32]);
    for (int i = 0; i < 4; i++) wr(4 + i, iv[i*32 +: 32]);
    cur_ctrl = 32'h1;  // ECB encrypt, 128-bit key
    wr(0, cur_ctrl);
    rd(0, w); chk("R1 ctrl written while disabled", 128'(w), 128'h1);

    for (int b = 0; b < 3; b++) begin
      p = r128();
      s0 = starts;
      load_words(p, 3);
      repeat (3) @(negedge clk);
      chk("R3 no start after three words", 128'(starts), 128'(s0));
      load_words({p[31:0], 96'd0}, 1);
      wait_done();
      chk("R3 core input MSB first", last_in, p);
      chk("R12 key size 128 to core", 128'(last_k256), 128'd0);
      get_block(r);
      chk("R5 ECB result", r, core_f(p, key, 1'b0, 1'b0));
      rd(3, w); chk("R5 fifth read is zero", 128'(w), 128'd0);
      wr(0, cur_ctrl | 32'h100);
      rd(1, w); chk("R6 flag cleared", 128'(w), 128'd0);
    end

    // R10: writes during computation and before clear
    p = r128();
    load_words(p, 4);
    wr(2, 32'hdead_beef);
    wait_done();
    wr(2, 32'h1234_5678);
    rd(1, w); chk("R10 write error flagged", 128'(w[1:0]), 128'd3);
    get_block(r);
    chk("R10 ignored writes leave result", r, core_f(p, key, 1'b0, 1'b0));
    wr(0, cur_ctrl | 32'h100);
    rd(1, w); chk("R6 clear drops write error", 128'(w), 128'd0);
    p = r128();
    run_block(p, r);
    chk("R10 word count not advanced", r, core_f(p, key, 1'b0, 1'b0));

    // R1: key and direction locked while enabled
    wr(8, ~key[31:0]);
    wr(0, cur_ctrl | 32'h2);
    rd(0, w); chk("R1 direction locked", 128'(w), 128'h1);
    p = r128();
    run_block(p, r);
    chk("R1 key locked", r, core_f(p, key, 1'b0, 1'b0));
    chk("R6 key reused across blocks", 128'(core_key), 128'(key));

    // CBC encrypt, 256-bit key, fresh IV
    wr(0, 32'h0);
    iv = r128();
    for (int i = 0; i < 4; i++) wr(4 + i, iv[i*32 +: 32]);
    cur_ctrl = 32'h25;
    wr(0, cur_ctrl);
    chain = iv;
    for (int b = 0; b < 3; b++) begin
      pts[b] = r128();
      run_block(pts[b], r);
      e = core_f(pts[b] ^ chain, key, 1'b1, 1'b0);
      if (b == 0) chk("R9 first block uses IV", r, e);
      else chk("R7 CBC encrypt chain", r, e);
      chk("R12 key size 256 to core", 128'(last_k256), 128'd1);
      cts[b] = r; chain = r;
    end

    // CBC decrypt of the same ciphertext
    wr(0, 32'h0);
    cur_ctrl = 32'h27;
    wr(0, cur_ctrl);
    chain = iv;
    for (int b = 0; b < 3; b++) begin
      run_block(cts[b], r);
      chk("R8 CBC decrypt restores plaintext", r, pts[b]);
      chk("R8 CBC decrypt core input raw", last_in, cts[b]);
      chain = cts[b];
    end

    // R2: reserved mode code behaves as ECB
    wr(0, 32'h0);
    cur_ctrl = 32'h9;
    wr(0, cur_ctrl);
    p = r128();
    run_block(p, r);
    chk("R2 code 010 as ECB", r, core_f(p, key, 1'b0, 1'b0));
    run_block(p, r);
    chk("R2 no chaining on repeat", r, core_f(p, key, 1'b0, 1'b0));

    // R11: abort mid-load and mid-computation
    wr(0, 32'h0);
    cur_ctrl = 32'h5;
    wr(0, cur_ctrl);
    p = r128();
    run_block(p, r);
    chk("R9 CBC first block", r, core_f(p ^ iv, key, 1'b0, 1'b0));
    load_words(r128(), 2);
    wr(0, 32'h0);
    rd(1, w); chk("R11 status cleared on disable", 128'(w), 128'd0);
    wr(0, cur_ctrl);
    p2 = r128();
    run_block(p2, r);
    chk("R11 chain and count reset", r, core_f(p2 ^ iv, key, 1'b0, 1'b0));
    load_words(r128(), 4);
    wr(0, 32'h0);
    repeat (8) @(negedge clk);
    wr(0, cur_ctrl);
    rd(1, w); chk("R11 late done ignored", 128'(w), 128'd0);
    p2 = r128();
    run_block(p2, r);
    chk("R11 restart after busy abort", r, core_f(p2 ^ iv, key, 1'b0, 1'b0));

    finish_run();
  end
endmodule